// File: doc/BRIEF.md
# Rotating Waveform Store

This block holds the sample tables of a five-voice wavetable sound generator and can make their contents rotate in place. There are four tables of 32 signed bytes each: voices 1, 2 and 3 own one table apiece, and voices 4 and 5 share the fourth table. Every table keeps a 5-bit start offset. When a table is rotating, its offset moves forward by one each time the voice that drives it reads out a sample. The sample-advance pulses come from the tone generator, so any change to the tone period or to the global frequency scaling also changes the rotation speed.

A two-bit rotation mode comes from the register block. Mode 00 turns rotation off. Mode 01 rotates all four tables, and the shared table follows voice 5. Modes 10 and 11 rotate only the shared table, and it follows voice 4. A table that is rotating is read-only. The block reports which tables are locked on a plain status vector so that the bus interface can see it. Bus reads and bus writes both go through the table's current offset. As a result, a table that is not rotating behaves like ordinary RAM, whatever offset it kept from an earlier rotation. A table that is rotating returns a different byte at the same index after every advance of its voice.

The bus read path has a fixed latency of one cycle and no back-pressure: every accepted read produces a response in the next cycle, and the response cannot be stalled. The control and status pins are level signals.

Top module: `wave_rotator`

## Requirements
- R1: Reset clears all four offsets to zero and holds `rd_valid` low. After reset, a read of index i returns the byte last written at index i.
- R2: When `rot_mode` is 00, `ro_mask` is 0000 and no table rotates. Bit k of `ro_mask` corresponds to table k, where tables 0 to 2 belong to voices 1 to 3 and table 3 is the shared table.
- R3: When `rot_mode` is 01, `ro_mask` is 1111. Table k (k = 0, 1, 2) advances its offset on `adv[k]`, and table 3 advances on `adv[4]` only.
- R4: When `rot_mode` is 10 or 11, `ro_mask` is 1000. Only table 3 advances, and it does so on `adv[3]`. `adv[4]` and `adv[2:0]` have no effect on any offset.
- R5: The address fields are: bits [6:5] select the table and bits [4:0] give the index. A read accepted in cycle t raises `rd_valid` in cycle t+1, with `rd_data` equal to the entry at (index + offset) mod 32 of that table, using the offset as it stood in cycle t.
- R6: A bus write to a table whose `ro_mask` bit is set changes no stored byte.
- R7: A bus write to a table that is not rotating stores the byte at (index + offset) mod 32, so that a later read of the same index returns it while the offset is unchanged.
- R8: An offset keeps its value in every cycle in which its table is not rotating, including after rotation has been switched off.
- R9: An offset wraps from 31 to 0 on its next advance.
- R10: If a read and a write hit the same entry in the same cycle, the read returns the byte that was stored before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rot_mode | input | 2 | Rotation mode: 00 off, 01 all tables, 1x shared table only |
| adv | input | 5 | One-cycle sample-advance pulse per voice (bit v is voice v+1) |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | 7 | Write address: table in [6:5], index in [4:0] |
| wr_data | input | 8 | Write byte |
| rd_en | input | 1 | Bus read strobe; always accepted |
| rd_addr | input | 7 | Read address: table in [6:5], index in [4:0] |
| rd_data | output | 8 | Read byte, valid with `rd_valid` |
| rd_valid | output | 1 | Read response, one cycle after `rd_en` |
| ro_mask | output | 4 | Bit k set while table k is rotating and read-only |

## Verification
An offset that is wrong by even one step shows up at the ports on the very next read of that table: `rd_data` comes out as a neighbouring byte, one cycle after the request. The tables are filled with distinct bytes so that every shift is visible. If an advance goes to the wrong table, or follows the wrong voice for the shared table, the result appears as a mismatch on the first read after the misrouted pulse. A leaked write can only be seen once that entry is read back. For that reason the random phase reads heavily and keeps exact offset and content models.

// File: rtl/wave_rot_pkg.sv
package wave_rot_pkg;
  localparam int NUM_WAVES = 4;
  localparam int NUM_VOICES = 5;
  localparam int WSEL_W = $clog2(NUM_WAVES);

  typedef enum logic [1:0] {
    ROT_OFF        = 2'b00,
    ROT_ALL        = 2'b01,
    ROT_SHARED     = 2'b10,
    ROT_SHARED_ALT = 2'b11
  } rot_mode_e;
endpackage

// File: rtl/rot_select.sv
module rot_select
  import wave_rot_pkg::*;
(
  input  logic [1:0]            mode,
  input  logic [NUM_VOICES-1:0] adv,
  output logic [NUM_WAVES-1:0]  rot_en,
  output logic [NUM_WAVES-1:0]  step
);
  rot_mode_e mode_e;
  assign mode_e = rot_mode_e'(mode);

  // tables owned by a single voice rotate only in the all-tables mode
  for (genvar k = 0; k < NUM_WAVES - 1; k++) begin : g_own
    assign rot_en[k] = (mode_e == ROT_ALL);
    assign step[k]   = rot_en[k] & adv[k];
  end

  // shared table: follows voice 5 in all-tables mode, voice 4 otherwise
  logic shared_src;
  always_comb begin
    shared_src = 1'b0;
    unique case (mode_e)
      ROT_ALL:                    shared_src = adv[NUM_VOICES-1];
      ROT_SHARED, ROT_SHARED_ALT: shared_src = adv[NUM_VOICES-2];
      default:                    shared_src = 1'b0;
    endcase
  end

  assign rot_en[NUM_WAVES-1] = (mode_e != ROT_OFF);
  assign step[NUM_WAVES-1]   = rot_en[NUM_WAVES-1] & shared_src;
endmodule

// File: rtl/rot_base_ctr.sv
module rot_base_ctr #(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [IDX_W-1:0] base
);
  always_ff @(posedge clk) begin
    if (!rst_n)    base <= '0;
    else if (step) base <= base + 1'b1;
  end
endmodule

// File: rtl/rot_wave_ram.sv
module rot_wave_ram #(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 5,
  parameter int WSEL_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [WSEL_W-1:0] w_wave,
  input  logic [IDX_W-1:0]  w_idx,
  input  logic [DATA_W-1:0] w_data,
  input  logic              re,
  input  logic [WSEL_W-1:0] r_wave,
  input  logic [IDX_W-1:0]  r_idx,
  output logic [DATA_W-1:0] r_data,
  output logic              r_valid
);
  localparam int DEPTH = 1 << (WSEL_W + IDX_W);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[{w_wave, w_idx}] <= w_data;
  end

  always_ff @(posedge clk) begin
    if (re) r_data <= mem[{r_wave, r_idx}];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) r_valid <= 1'b0;
    else        r_valid <= re;
  end
endmodule

// File: rtl/wave_rotator.sv
module wave_rotator
  import wave_rot_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 5,
  localparam int ADDR_W = WSEL_W + IDX_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            rot_mode,
  input  logic [NUM_VOICES-1:0] adv,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic                  rd_en,
  input  logic [ADDR_W-1:0]     rd_addr,
  output logic [DATA_W-1:0]     rd_data,
  output logic                  rd_valid,
  output logic [NUM_WAVES-1:0]  ro_mask
);
  logic [NUM_WAVES-1:0]       rot_en;
  logic [NUM_WAVES-1:0]       step;
  logic [IDX_W-1:0]           base [NUM_WAVES];
  logic [NUM_WAVES*IDX_W-1:0] base_flat;

  rot_select u_sel (
    .mode   (rot_mode),
    .adv    (adv),
    .rot_en (rot_en),
    .step   (step)
  );

  for (genvar k = 0; k < NUM_WAVES; k++) begin : g_base
    rot_base_ctr #(.IDX_W(IDX_W)) u_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (step[k]),
      .base  (base[k])
    );
    assign base_flat[k*IDX_W +: IDX_W] = base[k];
  end

  // address split and remap through the table offset
  logic [WSEL_W-1:0] w_wave, r_wave;
  logic [IDX_W-1:0]  w_phys, r_phys;
  logic              wr_go;

  assign w_wave = wr_addr[ADDR_W-1 -: WSEL_W];
  assign r_wave = rd_addr[ADDR_W-1 -: WSEL_W];
  assign w_phys = wr_addr[IDX_W-1:0] + base[w_wave];
  assign r_phys = rd_addr[IDX_W-1:0] + base[r_wave];
  assign wr_go  = wr_en & ~rot_en[w_wave];

  rot_wave_ram #(.DATA_W(DATA_W), .IDX_W(IDX_W), .WSEL_W(WSEL_W)) u_ram (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (wr_go),
    .w_wave  (w_wave),
    .w_idx   (w_phys),
    .w_data  (wr_data),
    .re      (rd_en),
    .r_wave  (r_wave),
    .r_idx   (r_phys),
    .r_data  (rd_data),
    .r_valid (rd_valid)
  );

  assign ro_mask = rot_en;
endmodule

// File: rtl/wave_rotator_chk.sv
module wave_rotator_chk #(
  parameter int IDX_W  = 5,
  parameter int ADDR_W = 7
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [1:0]           rot_mode,
  input logic [4:0]           adv,
  input logic                 wr_en,
  input logic [ADDR_W-1:0]    wr_addr,
  input logic                 rd_en,
  input logic                 rd_valid,
  input logic [3:0]           ro_mask,
  input logic [4*IDX_W-1:0]   base_flat,
  input logic                 ram_we
);
  logic [IDX_W-1:0] b0, b3, b0_inc;
  assign b0     = base_flat[0 +: IDX_W];
  assign b3     = base_flat[3*IDX_W +: IDX_W];
  assign b0_inc = b0 + 1'b1;

  assert_off_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rot_mode == 2'b00 |-> ro_mask == 4'b0000);

  assert_all_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rot_mode == 2'b01 |-> ro_mask == 4'b1111);

  assert_shared_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rot_mode[1] |-> ro_mask == 4'b1000);

  assert_step_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ro_mask[0] && adv[0]) |=> b0 == $past(b0_inc));

  assert_hold_own_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ro_mask[0] |=> $stable(b0));

  assert_hold_shared_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ro_mask[3] |=> $stable(b3));

  assert_shared_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rot_mode[1] && !adv[3]) |=> $stable(b3));

  assert_wr_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ro_mask[wr_addr[ADDR_W-1 -: 2]]) |-> !ram_we);

  assert_rd_resp_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

  assert_rd_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);
endmodule

bind wave_rotator wave_rotator_chk #(.IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rot_mode  (rot_mode),
  .adv       (adv),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .rd_en     (rd_en),
  .rd_valid  (rd_valid),
  .ro_mask   (ro_mask),
  .base_flat (base_flat),
  .ram_we    (wr_go)
);

// File: tb/test_wave_rotator.sv
`timescale 1ns/100ps
module test_wave_rotator;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] rot_mode = 2'b00;
  logic [4:0] adv = '0;
  logic       wr_en = 1'b0;
  logic [6:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       rd_en = 1'b0;
  logic [6:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       rd_valid;
  logic [3:0] ro_mask;

  int checks = 0;
  int errors = 0;
  int base_m [4];
  logic [7:0] mem_m [128];

  always #2.5 clk = ~clk;

  wave_rotator i_wave_rotator (
    .clk(clk), .rst_n(rst_n), .rot_mode(rot_mode), .adv(adv),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .rd_valid(rd_valid), .ro_mask(ro_mask)
  );

  function automatic logic [3:0] ro_of(input logic [1:0] m);
    if (m == 2'b00)      return 4'b0000;
    else if (m == 2'b01) return 4'b1111;
    else                 return 4'b1000;
  endfunction

  function automatic logic adv_of(input int k, input logic [1:0] m, input logic [4:0] a);
    if (k < 3)           return a[k];
    else if (m == 2'b01) return a[4];
    else                 return a[3];
  endfunction

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // one clock: inputs already driven at the falling edge
  task automatic tick(input string tag);
    logic [3:0] ro;
    logic [7:0] exp_d;
    logic       exp_v;
    int w, p;
    #1;
    ro = ro_of(rot_mode);
    check(ro_mask == ro, {tag, " mask"}, ro_mask, ro);
    exp_v = rd_en;
    exp_d = '0;
    if (rd_en) begin
      w = int'(rd_addr[6:5]);
      p = (int'(rd_addr[4:0]) + base_m[w]) % 32;
      exp_d = mem_m[w*32 + p];
    end
    if (wr_en) begin
      w = int'(wr_addr[6:5]);
      if (!ro[w]) begin
        p = (int'(wr_addr[4:0]) + base_m[w]) % 32;
        mem_m[w*32 + p] = wr_data;
      end
    end
    for (int k = 0; k < 4; k++)
      if (ro[k] && adv_of(k, rot_mode, adv)) base_m[k] = (base_m[k] + 1) % 32;
    @(posedge clk);
    @(negedge clk);
    check(rd_valid == exp_v, {tag, " valid"}, rd_valid, exp_v);
    if (exp_v) check(rd_data == exp_d, {tag, " data"}, rd_data, exp_d);
  endtask

  task automatic idle();
    wr_en = 1'b0; rd_en = 1'b0; adv = '0;
  endtask

  task automatic do_read(input int a, input string tag);
    idle(); rd_en = 1'b1; rd_addr = 7'(a); tick(tag); idle();
  endtask

  task automatic do_write(input int a, input logic [7:0] d, input string tag);
    idle(); wr_en = 1'b1; wr_addr = 7'(a); wr_data = d; tick(tag); idle();
  endtask

  task automatic pulse(input logic [4:0] a, input string tag);
    idle(); adv = a; tick(tag); idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int k = 0; k < 4; k++) base_m[k] = 0;
    for (int i = 0; i < 128; i++) mem_m[i] = '0;

    // R1: reset state
    repeat (3) @(negedge clk);
    check(rd_valid == 1'b0, "R1 valid in reset", rd_valid, 0);
    check(ro_mask == 4'b0000, "R1 mask in reset", ro_mask, 0);
    rst_n = 1'b1;

    // R2 / R7: fill all tables in mode 00, read back (offsets zero after R1)
    for (int i = 0; i < 128; i++) do_write(i, 8'(i * 37 + 5), "R7 fill");
    for (int i = 0; i < 128; i++) do_read(i, "R1 R2 readback");

    // R3 / R9: all-tables mode, table 0 wraps after 32 steps
    rot_mode = 2'b01;
    pulse(5'b00001, "R3 step t0");
    do_read(31, "R9 index 31 of t0");
    for (int i = 0; i < 31; i++) pulse(5'b00001, "R3 steps");
    do_read(0, "R9 wrapped t0");
    pulse(5'b01000, "R3 adv4 ignored");
    do_read(96, "R3 shared follows voice5");
    pulse(5'b10000, "R3 voice5 step");
    do_read(96, "R3 shared after voice5");
    do_write(2, 8'hA5, "R6 blocked t0");
    do_read(2, "R6 t0 unchanged");

    // R4: shared-only modes
    rot_mode = 2'b10;
    pulse(5'b10111, "R4 others ignored");
    do_read(96, "R4 shared held");
    do_read(33, "R4 t1 read");
    pulse(5'b01000, "R4 voice4 step");
    do_read(96, "R4 shared stepped");
    do_write(100, 8'h3C, "R6 blocked shared");
    do_write(40, 8'h77, "R4 t1 writable");
    do_read(40, "R7 t1 readback");
    rot_mode = 2'b11;
    pulse(5'b01000, "R4 mode11 step");
    do_read(97, "R4 mode11 read");

    // R8: offsets held after rotation stops; R7 writes through offset
    rot_mode = 2'b00;
    pulse(5'b11111, "R8 pulses ignored");
    do_read(0, "R8 t0 held");
    do_read(96, "R8 shared held");
    do_write(99, 8'hE1, "R7 shared write");
    do_read(99, "R7 shared readback");

    // R10: same-cycle read and write of one entry
    idle();
    wr_en = 1'b1; wr_addr = 7'd5; wr_data = 8'h5A;
    rd_en = 1'b1; rd_addr = 7'd5;
    tick("R10 read before write");
    do_read(5, "R10 new value");

    // random phase: R3 R4 R5 R6 R8 R9
    for (int n = 0; n < 6000; n++) begin
      if (($urandom % 48) == 0) rot_mode = 2'($urandom);
      adv     = 5'($urandom & $urandom);
      wr_en   = ($urandom % 3) == 0;
      wr_addr = 7'($urandom);
      wr_data = 8'($urandom);
      rd_en   = ($urandom % 2) == 0;
      rd_addr = ($urandom % 3 == 0) ? wr_addr : 7'($urandom);
      tick("R5 R6 random");
    end
    idle();
    rot_mode = 2'b00;
    for (int i = 0; i < 128; i++) do_read(i, "R8 final sweep");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule